// File: doc/BRIEF.md
# Power-Management Event and Control Register Block

This block sits on a byte-addressed I/O port bus and presents two small register windows used by system software for power management. The event window holds a status register that always reads as zero and an enable register that stores a 16-bit mask. The separate control window holds a write-only control register whose sleep request fields are decoded in hardware.

A soft-off request written to the control register raises a one-cycle power-off pulse that the platform uses to remove power. The block supports only that one sleep state. Any other requested sleep state produces a one-cycle error pulse. An enable-register write with the wrong access size produces the same error pulse, and so does an access to an unused offset inside either window. Read data is registered. Accesses that fall outside both windows are left to other devices on the bus.

Top module: `pm_regblock`

## Requirements
- R1: After a synchronous active-high reset the stored enable value is zero, both pulse outputs are low and the read data is zero.
- R2: A read of the status register (event window offset 0) returns zero. A write to it changes no state and raises no pulse.
- R3: Access size is coded as 0 = byte, 1 = 16-bit, 2 or 3 = 32-bit. A write to the enable register (event window offset 2) is accepted only with size 1. Any other size leaves the stored value unchanged and raises the error pulse.
- R4: A read of the enable register returns the last accepted 16-bit value in read-data bits 15:0, with the upper bits zero.
- R5: A control write (control window offset 0) with bit 13 set and bits 12:10 equal to 1 raises the power-off pulse for exactly one cycle. The pulse appears in the cycle after the write edge.
- R6: A control write with bit 13 set and any other value in bits 12:10 raises the error pulse for one cycle and no power-off pulse.
- R7: A control write with bit 13 clear raises no pulse. A read of the control register returns zero.
- R8: A read or write to an undefined offset inside a window (event offset 1, control offsets 1 and 2) raises the error pulse. A read of such an offset returns zero.
- R9: An access outside both windows raises no pulse, leaves the stored enable value unchanged and leaves the read data as it was.
- R10: Read data is updated on the clock edge at which the read strobe is sampled. It holds its value until the next read that hits a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busAddr | input | 16 | Byte I/O address |
| busWr | input | 1 | Write strobe, one cycle per access |
| busRd | input | 1 | Read strobe, one cycle per access |
| busSize | input | 2 | Access size code |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| powerOffPulse | output | 1 | One-cycle soft-off request |
| errorPulse | output | 1 | One-cycle rejected-access indication |

## Verification
The only internal state is the enable value. A corrupt or wrongly updated enable value stays hidden until the next read of offset 2, and it then appears in the read data one cycle after that read. The bench therefore reads the enable register back after every write that should not change it: wrong-size writes, status writes and accesses outside the windows. A fault in the sleep decode shows in the cycle right after the control write, as a wrong pulse or a missing pulse. The bench checks both pulse outputs at every access and in the idle cycle that follows, so a pulse that lasts longer than one cycle is also caught.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_ZERO   = 2'd1,
    RD_ENABLE = 2'd2
  } pmRdSel_t;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } pmSize_t;

  typedef struct packed {
    logic     enWr;
    logic     powerOff;
    logic     reject;
    pmRdSel_t rdSel;
  } pmStrobes_t;
endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
  import pm_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] EVT_BASE = 16'h0600,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'h0604,
  parameter int WIN_SPAN = 3,
  parameter int SLP_EN_BIT  = 13,
  parameter int SLP_TYP_LSB = 10,
  parameter int SLP_TYP_W   = 3,
  parameter int SOFT_OFF_TYP = 1
) (
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] wdata,
  output pmStrobes_t        stb
);
  localparam logic [ADDR_W-1:0] STATUS_OFF = '0;
  localparam logic [ADDR_W-1:0] ENABLE_OFF = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] CTRL_OFF   = '0;
  localparam logic [ADDR_W-1:0] SPAN       = ADDR_W'(WIN_SPAN);

  logic [ADDR_W-1:0]    evtOff;
  logic [ADDR_W-1:0]    ctlOff;
  logic                 evtHit;
  logic                 ctlHit;
  logic                 sleepEn;
  logic [SLP_TYP_W-1:0] sleepTyp;
  logic                 isStatus;
  logic                 isEnable;
  logic                 isCtrl;
  logic                 undefHit;

  always_comb begin
    evtOff   = addr - EVT_BASE;
    ctlOff   = addr - CTL_BASE;
    evtHit   = (addr >= EVT_BASE) && (evtOff < SPAN);
    ctlHit   = (addr >= CTL_BASE) && (ctlOff < SPAN);
    sleepEn  = wdata[SLP_EN_BIT];
    sleepTyp = wdata[SLP_TYP_LSB +: SLP_TYP_W];
    isStatus = evtHit && (evtOff == STATUS_OFF);
    isEnable = evtHit && (evtOff == ENABLE_OFF);
    isCtrl   = ctlHit && (ctlOff == CTRL_OFF);
    undefHit = (evtHit && !isStatus && !isEnable) || (ctlHit && !isCtrl);
  end

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    stb.enWr = wr && isEnable && (size == SZ_HALF);
    stb.powerOff = wr && isCtrl && sleepEn &&
                   (sleepTyp == SLP_TYP_W'(SOFT_OFF_TYP));
    stb.reject = (wr && isEnable && (size != SZ_HALF))
               || ((wr || rd) && undefHit)
               || (wr && isCtrl && sleepEn &&
                   (sleepTyp != SLP_TYP_W'(SOFT_OFF_TYP)));
    if (rd && isEnable) begin
      stb.rdSel = RD_ENABLE;
    end else if (rd && (evtHit || ctlHit)) begin
      stb.rdSel = RD_ZERO;
    end
  end
endmodule

// File: rtl/pm_datapath.sv
module pm_datapath
  import pm_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EN_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  pmStrobes_t        stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [EN_W-1:0]   enableQ,
  output logic              offQ,
  output logic              errQ
);
  localparam int PAD_W = DATA_W - EN_W;

  logic [DATA_W-1:0] enableWide;

  generate
    if (PAD_W > 0) begin : g_pad
      assign enableWide = {{PAD_W{1'b0}}, enableQ};
    end else begin : g_nopad
      assign enableWide = enableQ[DATA_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      enableQ <= '0;
      rdata   <= '0;
      offQ    <= 1'b0;
      errQ    <= 1'b0;
    end else begin
      offQ <= stb.powerOff;
      errQ <= stb.reject;
      if (stb.enWr) begin
        enableQ <= wdata[EN_W-1:0];
      end
      case (stb.rdSel)
        RD_ZERO:   rdata <= '0;
        RD_ENABLE: rdata <= enableWide;
        default:   rdata <= rdata;
      endcase
    end
  end
endmodule

// File: rtl/pm_regblock.sv
module pm_regblock
  import pm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int EN_W   = 16,
  parameter logic [ADDR_W-1:0] EVT_BASE = 16'h0600,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'h0604,
  parameter int WIN_SPAN = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [1:0]        busSize,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              powerOffPulse,
  output logic              errorPulse
);
  pmStrobes_t      stb;
  logic [EN_W-1:0] enableQ;

  pm_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .EVT_BASE(EVT_BASE), .CTL_BASE(CTL_BASE), .WIN_SPAN(WIN_SPAN)
  ) u_ctrl (
    .wr(busWr), .rd(busRd), .addr(busAddr), .size(busSize),
    .wdata(busWdata), .stb(stb)
  );

  pm_datapath #(.DATA_W(DATA_W), .EN_W(EN_W)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .wdata(busWdata),
    .rdata(busRdata), .enableQ(enableQ),
    .offQ(powerOffPulse), .errQ(errorPulse)
  );
endmodule

// File: rtl/pm_regblock_chk.sv
module pm_regblock_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int EN_W   = 16,
  parameter logic [ADDR_W-1:0] EVT_BASE = 16'h0600,
  parameter logic [ADDR_W-1:0] CTL_BASE = 16'h0604
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [1:0]        busSize,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              powerOffPulse,
  input logic              errorPulse,
  input logic [EN_W-1:0]   enableQ
);
  logic enAddr;
  logic ctlAddr;
  logic softOffWr;
  assign enAddr    = busAddr == EVT_BASE + ADDR_W'(2);
  assign ctlAddr   = busAddr == CTL_BASE;
  assign softOffWr = busWr && ctlAddr && busWdata[13] && (busWdata[12:10] == 3'd1);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (enableQ == '0) && !powerOffPulse && !errorPulse); // R1

  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busRd && busAddr == EVT_BASE) |=> busRdata == '0); // R2

  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(busWr && enAddr && busSize == 2'd1) |=> $stable(enableQ)); // R3

  AST_EN_SIZE_ERR: assert property (@(posedge clk) disable iff (rst)
    (busWr && enAddr && busSize != 2'd1) |=> errorPulse); // R3

  AST_OFF_CAUSE: assert property (@(posedge clk) disable iff (rst)
    powerOffPulse |-> $past(softOffWr)); // R5

  AST_OFF_SEEN: assert property (@(posedge clk) disable iff (rst)
    softOffWr |=> powerOffPulse && !errorPulse); // R5

  AST_CTRL_RD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (busRd && ctlAddr) |=> busRdata == '0); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !busRd |=> $stable(busRdata)); // R10
endmodule

bind pm_regblock pm_regblock_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EN_W(EN_W),
  .EVT_BASE(EVT_BASE), .CTL_BASE(CTL_BASE)
) u_chk (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
  .powerOffPulse(powerOffPulse), .errorPulse(errorPulse), .enableQ(enableQ)
);

// File: tb/sim_pm_regblock.sv
`timescale 1ns/1ps
module sim_pm_regblock;
  localparam logic [15:0] EVT = 16'h0600;
  localparam logic [15:0] CTL = 16'h0604;

  typedef struct {
    logic [31:0] rd;
    logic        off;
    logic        err;
    string       req;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] busAddr = '0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        powerOffPulse;
  logic        errorPulse;

  int checks = 0;
  int errors = 0;
  expItem_t q[$];

  always #2.5 clk = ~clk;

  pm_regblock u0 (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busSize(busSize), .busWdata(busWdata), .busRdata(busRdata),
    .powerOffPulse(powerOffPulse), .errorPulse(errorPulse)
  );

  task automatic busOp(input bit w, input bit r, input logic [15:0] a,
                       input logic [1:0] s, input logic [31:0] d,
                       input logic [31:0] expRd, input bit expOff,
                       input bit expErr, input string req);
    expItem_t it;
    @(negedge clk);
    busWr = w; busRd = r; busAddr = a; busSize = s; busWdata = d;
    @(posedge clk);
    #1;
    it.rd = expRd; it.off = expOff; it.err = expErr; it.req = req;
    q.push_back(it);
    busWr = 1'b0; busRd = 1'b0;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      expItem_t it;
      it = q.pop_front();
      checks++;
      if (busRdata !== it.rd || powerOffPulse !== it.off || errorPulse !== it.err) begin
        errors++;
        $display("FAIL %s: actual rd=%h off=%b err=%b expected rd=%h off=%b err=%b",
                 it.req, busRdata, powerOffPulse, errorPulse, it.rd, it.off, it.err);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (busRdata !== '0 || powerOffPulse !== 1'b0 || errorPulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual rd=%h off=%b err=%b expected rd=0 off=0 err=0",
               busRdata, powerOffPulse, errorPulse);
    end
    // R1: enable reads zero after reset
    busOp(0, 1, EVT + 16'd2, 2'd1, '0, 32'h0, 0, 0, "R1");
    // R3/R4: accepted 16-bit write and readback
    busOp(1, 0, EVT + 16'd2, 2'd1, 32'hFFFF_A5C3, 32'h0, 0, 0, "R3");
    busOp(0, 1, EVT + 16'd2, 2'd1, '0, 32'h0000_A5C3, 0, 0, "R4");
    // R3: byte and word writes rejected, value kept
    busOp(1, 0, EVT + 16'd2, 2'd0, 32'h0000_0011, 32'h0000_A5C3, 0, 1, "R3");
    busOp(1, 0, EVT + 16'd2, 2'd2, 32'h0000_2222, 32'h0000_A5C3, 0, 1, "R3");
    busOp(0, 1, EVT + 16'd2, 2'd1, '0, 32'h0000_A5C3, 0, 0, "R3");
    // R2: status reads zero, write ignored
    busOp(0, 1, EVT, 2'd1, '0, 32'h0, 0, 0, "R2");
    busOp(1, 0, EVT, 2'd1, 32'h0000_FFFF, 32'h0, 0, 0, "R2");
    busOp(0, 1, EVT + 16'd2, 2'd1, '0, 32'h0000_A5C3, 0, 0, "R2");
    // R5: soft-off, one cycle, back to back
    busOp(1, 0, CTL, 2'd1, 32'h0000_2400, 32'h0000_A5C3, 1, 0, "R5");
    busOp(0, 0, '0, 2'd0, '0, 32'h0000_A5C3, 0, 0, "R5");
    busOp(1, 0, CTL, 2'd2, 32'h0000_2400, 32'h0000_A5C3, 1, 0, "R5");
    busOp(1, 0, CTL, 2'd2, 32'h0000_2400, 32'h0000_A5C3, 1, 0, "R5");
    // R6: other sleep types
    busOp(1, 0, CTL, 2'd1, 32'h0000_2000, 32'h0000_A5C3, 0, 1, "R6");
    busOp(1, 0, CTL, 2'd1, 32'h0000_3C00, 32'h0000_A5C3, 0, 1, "R6");
    busOp(1, 0, CTL, 2'd1, 32'h0000_2800, 32'h0000_A5C3, 0, 1, "R6");
    // R7: sleep-enable clear, control read zero
    busOp(1, 0, CTL, 2'd1, 32'h0000_1C00, 32'h0000_A5C3, 0, 0, "R7");
    busOp(0, 1, CTL, 2'd1, '0, 32'h0, 0, 0, "R7");
    // R8: undefined offsets
    busOp(0, 1, EVT + 16'd2, 2'd1, '0, 32'h0000_A5C3, 0, 0, "R8");
    busOp(0, 1, EVT + 16'd1, 2'd0, '0, 32'h0, 0, 1, "R8");
    busOp(1, 0, CTL + 16'd2, 2'd0, 32'h0000_2400, 32'h0, 0, 1, "R8");
    busOp(0, 1, CTL + 16'd1, 2'd0, '0, 32'h0, 0, 1, "R8");
    // R9/R10: outside windows, read data held
    busOp(0, 1, EVT + 16'd2, 2'd1, '0, 32'h0000_A5C3, 0, 0, "R10");
    busOp(0, 1, 16'h0700, 2'd1, '0, 32'h0000_A5C3, 0, 0, "R9");
    busOp(1, 0, EVT + 16'd3, 2'd1, 32'h0000_2400, 32'h0000_A5C3, 0, 0, "R9");
    busOp(1, 0, EVT - 16'd1, 2'd1, 32'h0000_1234, 32'h0000_A5C3, 0, 0, "R9");
    busOp(0, 0, '0, 2'd0, '0, 32'h0000_A5C3, 0, 0, "R10");
    busOp(0, 1, EVT + 16'd2, 2'd1, '0, 32'h0000_A5C3, 0, 0, "R9");
    // R4: second value, upper bits zero
    busOp(1, 0, EVT + 16'd2, 2'd1, 32'hDEAD_0001, 32'h0000_A5C3, 0, 0, "R4");
    busOp(0, 1, EVT + 16'd2, 2'd3, '0, 32'h0000_0001, 0, 0, "R4");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule